// File: doc/BRIEF.md
# Condition Register Unit

This block holds a processor's 32-bit condition register. The register is split into eight 4-bit fields. Each field carries, from its most significant bit down, a less-than flag, a greater-than flag, an equal flag and a summary-overflow flag. Seven independent update sources can ask to change the register. At most one of them takes effect per clock, and the lowest-numbered source always wins. The update sources are:

- recorded integer results
- recorded floating-point status
- masked moves from a general-purpose register
- field-to-field copies
- loads from the fixed-point exception register
- explicit compares
- single-bit logical operations

Instruction decode, the ALU, the floating-point unit and the exception register are outside this block. Their results arrive on plain input pins. Every request is a single-cycle strobe with no back-pressure: the unit never stalls, and a request that loses arbitration is dropped, not held. The whole register is always visible on `cr_q`. A one-bit combinational read port serves branch evaluation. Reset leaves the register contents alone, so software must write the register before it relies on it.

Top module: `cond_reg_unit`

## Requirements
- R1: Bit 0 of the register is `cr_q[31]` and bit i is `cr_q[31-i]`. Field n covers bits 4n..4n+3, with the less-than flag at bit 4n and summary-overflow at bit 4n+3. `test_bit` shows register bit `test_idx` combinationally.
- R2: When `int_rec_vld` wins, field 0's upper three flags become less-than, greater-than or equal (exactly one is set) from a signed comparison of `int_result` with zero.
- R3: On that integer update and on a compare update, the summary-overflow flag takes `xer_top[3]`, the exception register's summary-overflow bit, in the same cycle.
- R4: When `fp_rec_vld` wins, field 1 is loaded with `fp_status`, where `fp_status[3]` goes to bit 4.
- R5: When `mov_vld` wins, each field n with `mov_mask[n]` set takes the same bit positions of `mov_data`. Fields whose mask bit is clear are unchanged.
- R6: When `cpy_vld` wins, field `cpy_dst` takes the pre-update contents of field `cpy_src`. A copy onto itself leaves the field unchanged.
- R7: When `xer_ld_vld` wins, field `xer_ld_fld` is loaded with `xer_top`, and `xer_clr` is high in that same cycle. `xer_clr` is high in no other cycle.
- R8: When `cmp_vld` wins, field `cmp_fld` gets the less-than, greater-than and equal flags of `cmp_a` against `cmp_b`. The comparison is unsigned when `cmp_unsigned` is 1 and signed when it is 0.
- R9: When `bit_vld` wins, register bit `bit_dst` becomes op(bit `bit_a`, bit `bit_b`), read before the update. The `bit_op` codes are 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR, 6 a AND NOT b, 7 a OR NOT b.
- R10: The request priority is int_rec, fp_rec, mov, cpy, xer_ld, cmp, bit, highest first. Every request other than the highest valid one has no effect.
- R11: With no request valid, and across a reset pulse, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (does not clear the register) |
| int_rec_vld | input | 1 | Recorded integer result strobe |
| int_result | input | 32 | Integer result |
| fp_rec_vld | input | 1 | Recorded floating-point strobe |
| fp_status | input | 4 | Top four floating-point status bits |
| mov_vld | input | 1 | Masked move strobe |
| mov_mask | input | 8 | Field mask, bit n selects field n |
| mov_data | input | 32 | General-purpose register value |
| cpy_vld | input | 1 | Field copy strobe |
| cpy_src | input | 3 | Source field index |
| cpy_dst | input | 3 | Destination field index |
| xer_ld_vld | input | 1 | Exception-register load strobe |
| xer_ld_fld | input | 3 | Destination field index |
| xer_top | input | 4 | Top four exception-register bits, [3] is summary overflow |
| xer_clr | output | 1 | Clear strobe for those four bits |
| cmp_vld | input | 1 | Compare strobe |
| cmp_fld | input | 3 | Destination field index |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| cmp_unsigned | input | 1 | 1 selects an unsigned compare |
| bit_vld | input | 1 | Bit-logic strobe |
| bit_op | input | 3 | Logic operation code |
| bit_a | input | 5 | First source bit index |
| bit_b | input | 5 | Second source bit index |
| bit_dst | input | 5 | Destination bit index |
| test_idx | input | 5 | Bit index for the branch read |
| test_bit | output | 1 | Selected register bit |
| cr_q | output | 32 | Full register |

## Verification
The bench builds the unit with its default parameters: eight 4-bit fields and 32-bit operands. With these values every one of the 32 bit indices, all eight field indices and all 256 move masks can be reached by random stimulus. Random strobes overlap often, so priority resolution among all seven sources is exercised. Directed cases cover the sign boundaries of both compares, self-copy, the exception-register clear strobe, and a reset pulse that must leave the contents intact.

// File: rtl/cru_pkg.sv
package cru_pkg;

  typedef enum logic [2:0] {
    BL_AND  = 3'd0,
    BL_OR   = 3'd1,
    BL_XOR  = 3'd2,
    BL_NAND = 3'd3,
    BL_NOR  = 3'd4,
    BL_XNOR = 3'd5,
    BL_ANDC = 3'd6,
    BL_ORC  = 3'd7
  } bitop_e;

  // Request slots, lower index has higher priority
  localparam int REQ_INT = 0;
  localparam int REQ_FPX = 1;
  localparam int REQ_MOV = 2;
  localparam int REQ_CPY = 3;
  localparam int REQ_XER = 4;
  localparam int REQ_CMP = 5;
  localparam int REQ_BIT = 6;
  localparam int NUM_REQ = 7;

endpackage

// File: rtl/cru_prio_arb.sv
module cru_prio_arb #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [N-1:0] seen;

  for (genvar k = 0; k < N; k++) begin : g_slot
    if (k == 0) begin : g_first
      assign seen[k] = 1'b0;
    end else begin : g_rest
      assign seen[k] = seen[k-1] | req[k-1];
    end
    assign gnt[k] = req[k] & ~seen[k];
  end

  assert_gnt_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_gnt_when_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
  assert_gnt_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/cru_cmp.sv
module cru_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         uns,
  output logic         lt,
  output logic         gt,
  output logic         eq
);

  logic lt_s, lt_u;

  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;
  assign eq   = (a == b);
  assign lt   = uns ? lt_u : lt_s;
  assign gt   = ~lt & ~eq;

endmodule

// File: rtl/cru_bitop.sv
module cru_bitop
  import cru_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic [2:0] op,
  output logic       y
);

  bitop_e op_e;
  assign op_e = bitop_e'(op);

  always_comb begin
    unique case (op_e)
      BL_AND:  y = a & b;
      BL_OR:   y = a | b;
      BL_XOR:  y = a ^ b;
      BL_NAND: y = ~(a & b);
      BL_NOR:  y = ~(a | b);
      BL_XNOR: y = ~(a ^ b);
      BL_ANDC: y = a & ~b;
      BL_ORC:  y = a | ~b;
      default: y = 1'b0;
    endcase
  end

endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit
  import cru_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  parameter int DATA_W     = 32,
  localparam int CR_W      = NUM_FIELDS * FIELD_W,
  localparam int FIDX_W    = $clog2(NUM_FIELDS),
  localparam int BIDX_W    = $clog2(CR_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  int_rec_vld,
  input  logic [DATA_W-1:0]     int_result,
  input  logic                  fp_rec_vld,
  input  logic [FIELD_W-1:0]    fp_status,
  input  logic                  mov_vld,
  input  logic [NUM_FIELDS-1:0] mov_mask,
  input  logic [CR_W-1:0]       mov_data,
  input  logic                  cpy_vld,
  input  logic [FIDX_W-1:0]     cpy_src,
  input  logic [FIDX_W-1:0]     cpy_dst,
  input  logic                  xer_ld_vld,
  input  logic [FIDX_W-1:0]     xer_ld_fld,
  input  logic [FIELD_W-1:0]    xer_top,
  output logic                  xer_clr,
  input  logic                  cmp_vld,
  input  logic [FIDX_W-1:0]     cmp_fld,
  input  logic [DATA_W-1:0]     cmp_a,
  input  logic [DATA_W-1:0]     cmp_b,
  input  logic                  cmp_unsigned,
  input  logic                  bit_vld,
  input  logic [2:0]            bit_op,
  input  logic [BIDX_W-1:0]     bit_a,
  input  logic [BIDX_W-1:0]     bit_b,
  input  logic [BIDX_W-1:0]     bit_dst,
  input  logic [BIDX_W-1:0]     test_idx,
  output logic                  test_bit,
  output logic [CR_W-1:0]       cr_q
);

  localparam logic [BIDX_W-1:0] TOPB = BIDX_W'(CR_W - 1);

  logic [NUM_REQ-1:0] req, gnt;
  assign req = {bit_vld, cmp_vld, xer_ld_vld, cpy_vld, mov_vld, fp_rec_vld, int_rec_vld};

  cru_prio_arb #(.N(NUM_REQ)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .gnt  (gnt)
  );

  // Flag generation
  logic int_lt, int_gt, int_eq;
  logic cmp_lt, cmp_gt, cmp_eq;
  logic so_in;

  cru_cmp #(.W(DATA_W)) u_int_cmp (
    .a  (int_result),
    .b  ({DATA_W{1'b0}}),
    .uns(1'b0),
    .lt (int_lt),
    .gt (int_gt),
    .eq (int_eq)
  );

  cru_cmp #(.W(DATA_W)) u_op_cmp (
    .a  (cmp_a),
    .b  (cmp_b),
    .uns(cmp_unsigned),
    .lt (cmp_lt),
    .gt (cmp_gt),
    .eq (cmp_eq)
  );

  assign so_in = xer_top[FIELD_W-1];

  logic [FIELD_W-1:0] int_nib, cmp_nib;
  assign int_nib = {int_lt, int_gt, int_eq, so_in};
  assign cmp_nib = {cmp_lt, cmp_gt, cmp_eq, so_in};

  // Field view and per-field next value
  logic [FIELD_W-1:0] fld     [NUM_FIELDS];
  logic [FIELD_W-1:0] nxt_fld [NUM_FIELDS];
  logic [FIELD_W-1:0] cpy_nib;
  logic [CR_W-1:0]    cr_mid, cr_nxt;

  assign cpy_nib = fld[cpy_src];

  for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_fld
    assign fld[n] = cr_q[CR_W-1-FIELD_W*n -: FIELD_W];

    always_comb begin
      nxt_fld[n] = fld[n];
      if (gnt[REQ_INT] && n == 0)
        nxt_fld[n] = int_nib;
      else if (gnt[REQ_FPX] && n == 1)
        nxt_fld[n] = fp_status;
      else if (gnt[REQ_MOV] && mov_mask[n])
        nxt_fld[n] = mov_data[CR_W-1-FIELD_W*n -: FIELD_W];
      else if (gnt[REQ_CPY] && cpy_dst == FIDX_W'(n))
        nxt_fld[n] = cpy_nib;
      else if (gnt[REQ_XER] && xer_ld_fld == FIDX_W'(n))
        nxt_fld[n] = xer_top;
      else if (gnt[REQ_CMP] && cmp_fld == FIDX_W'(n))
        nxt_fld[n] = cmp_nib;
    end

    assign cr_mid[CR_W-1-FIELD_W*n -: FIELD_W] = nxt_fld[n];
  end

  // Single-bit logic path
  logic bl_a, bl_b, bl_y;
  assign bl_a = cr_q[TOPB - bit_a];
  assign bl_b = cr_q[TOPB - bit_b];

  cru_bitop u_bitop (
    .a (bl_a),
    .b (bl_b),
    .op(bit_op),
    .y (bl_y)
  );

  always_comb begin
    cr_nxt = cr_mid;
    if (gnt[REQ_BIT])
      cr_nxt[TOPB - bit_dst] = bl_y;
  end

  // Contents survive reset by intent
  always_ff @(posedge clk) begin
    cr_q <= cr_nxt;
  end

  assign xer_clr  = gnt[REQ_XER];
  assign test_bit = cr_q[TOPB - test_idx];

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req) |=> $stable(cr_q));
  assert_int_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_rec_vld |=> $onehot(fld[0][FIELD_W-1:1]));
  assert_int_so_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_rec_vld |=> fld[0][0] == $past(xer_top[FIELD_W-1]));
  assert_fp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_rec_vld && !int_rec_vld) |=> fld[1] == $past(fp_status));
  assert_mov_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[REQ_MOV] && mov_mask == '0) |=> $stable(cr_q));
  assert_cpy_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[REQ_CPY] |=> fld[$past(cpy_dst)] == $past(cpy_nib));
  assert_xer_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xer_clr |-> (xer_ld_vld && !int_rec_vld && !fp_rec_vld && !mov_vld && !cpy_vld));
  assert_xer_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xer_clr |=> fld[$past(xer_ld_fld)] == $past(xer_top));

endmodule

// File: tb/cond_reg_unit_tb.sv
`timescale 1ns/1ps
module cond_reg_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_rec_vld = 0;
  logic [31:0] int_result = '0;
  logic        fp_rec_vld = 0;
  logic [3:0]  fp_status = '0;
  logic        mov_vld = 0;
  logic [7:0]  mov_mask = '0;
  logic [31:0] mov_data = '0;
  logic        cpy_vld = 0;
  logic [2:0]  cpy_src = '0, cpy_dst = '0;
  logic        xer_ld_vld = 0;
  logic [2:0]  xer_ld_fld = '0;
  logic [3:0]  xer_top = '0;
  logic        xer_clr;
  logic        cmp_vld = 0;
  logic [2:0]  cmp_fld = '0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        cmp_unsigned = 0;
  logic        bit_vld = 0;
  logic [2:0]  bit_op = '0;
  logic [4:0]  bit_a = '0, bit_b = '0, bit_dst = '0;
  logic [4:0]  test_idx = '0;
  logic        test_bit;
  logic [31:0] cr_q;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_cr = '0;
  bit m_valid = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_reg_unit dut_i (.*);

  function automatic logic gb(logic [31:0] c, int i);
    return c[31-i];
  endfunction

  function automatic logic [3:0] gf(logic [31:0] c, int n);
    return c[31-4*n -: 4];
  endfunction

  function automatic logic [3:0] flags(logic lt, logic gt, logic so);
    return {lt, gt, !lt && !gt, so};
  endfunction

  function automatic logic [31:0] ref_next(logic [31:0] c);
    logic [31:0] r = c;
    logic a, b, y;
    if (int_rec_vld) begin
      r[31 -: 4] = flags($signed(int_result) < 0, $signed(int_result) > 0, xer_top[3]);
    end else if (fp_rec_vld) begin
      r[27 -: 4] = fp_status;
    end else if (mov_vld) begin
      for (int n = 0; n < 8; n++)
        if (mov_mask[n]) r[31-4*n -: 4] = gf(mov_data, n);
    end else if (cpy_vld) begin
      r[31-4*cpy_dst -: 4] = gf(c, int'(cpy_src));
    end else if (xer_ld_vld) begin
      r[31-4*xer_ld_fld -: 4] = xer_top;
    end else if (cmp_vld) begin
      if (cmp_unsigned)
        r[31-4*cmp_fld -: 4] = flags(cmp_a < cmp_b, cmp_a > cmp_b, xer_top[3]);
      else
        r[31-4*cmp_fld -: 4] = flags($signed(cmp_a) < $signed(cmp_b),
                                     $signed(cmp_a) > $signed(cmp_b), xer_top[3]);
    end else if (bit_vld) begin
      a = gb(c, int'(bit_a));
      b = gb(c, int'(bit_b));
      case (bit_op)
        3'd0: y = a & b;
        3'd1: y = a | b;
        3'd2: y = a ^ b;
        3'd3: y = !(a & b);
        3'd4: y = !(a | b);
        3'd5: y = !(a ^ b);
        3'd6: y = a & !b;
        default: y = a | !b;
      endcase
      r[31-bit_dst] = y;
    end
    return r;
  endfunction

  function automatic string req_tag();
    int cnt = int'(int_rec_vld) + int'(fp_rec_vld) + int'(mov_vld) + int'(cpy_vld)
            + int'(xer_ld_vld) + int'(cmp_vld) + int'(bit_vld);
    if (cnt > 1) return "R10";
    if (int_rec_vld) return "R2/R3";
    if (fp_rec_vld) return "R4";
    if (mov_vld) return "R5";
    if (cpy_vld) return "R6";
    if (xer_ld_vld) return "R7";
    if (cmp_vld) return "R8";
    if (bit_vld) return "R9";
    return "R11";
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    int_rec_vld = 0; fp_rec_vld = 0; mov_vld = 0; cpy_vld = 0;
    xer_ld_vld = 0; cmp_vld = 0; bit_vld = 0;
  endtask

  // Called at a falling edge with inputs already driven
  task automatic step();
    logic [31:0] exp;
    string tag;
    logic exp_clr;
    exp = ref_next(m_cr);
    tag = req_tag();
    exp_clr = xer_ld_vld && !int_rec_vld && !fp_rec_vld && !mov_vld && !cpy_vld;
    #1;
    chk({31'd0, xer_clr}, {31'd0, exp_clr}, "R7 xer_clr");
    if (m_valid) chk({31'd0, test_bit}, {31'd0, gb(m_cr, int'(test_idx))}, "R1 test_bit");
    @(posedge clk);
    @(negedge clk);
    m_cr = exp;
    m_valid = 1;
    chk(cr_q, exp, tag);
  endtask

  task automatic load_all(logic [31:0] v);
    clear_reqs(); mov_vld = 1; mov_mask = 8'hFF; mov_data = v;
    step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R5: full write, then partial mask
    load_all(32'h0000_0000);
    load_all(32'hA5A5_3C3C);
    clear_reqs(); mov_vld = 1; mov_mask = 8'b1000_0001; mov_data = 32'hFFFF_FFFF;
    step(); // fields 0 and 7 only
    chk(cr_q, 32'hF5A5_3C3F, "R5 mask bit n selects field n");

    // R11: reset pulse keeps contents
    clear_reqs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cr_q, m_cr, "R11 reset keeps contents");
    step();

    // R1: bit numbering via test port
    load_all(32'h8000_0001);
    clear_reqs(); test_idx = 5'd0; #1;
    chk({31'd0, test_bit}, 32'd1, "R1 bit0 is msb");
    test_idx = 5'd31; #1;
    chk({31'd0, test_bit}, 32'd1, "R1 bit31 is lsb");
    test_idx = 5'd1; #1;
    chk({31'd0, test_bit}, 32'd0, "R1 bit1");
    @(negedge clk);

    // R2/R3: sign boundaries
    clear_reqs(); int_rec_vld = 1; xer_top = 4'b1000; int_result = 32'h8000_0000;
    step(); chk({28'd0, gf(cr_q, 0)}, 32'h9, "R2 negative, R3 so");
    clear_reqs(); int_rec_vld = 1; xer_top = 4'b0111; int_result = 32'h7FFF_FFFF;
    step(); chk({28'd0, gf(cr_q, 0)}, 32'h4, "R2 positive");
    clear_reqs(); int_rec_vld = 1; int_result = 32'h0;
    step(); chk({28'd0, gf(cr_q, 0)}, 32'h2, "R2 zero");

    // R8: unsigned vs signed
    clear_reqs(); cmp_vld = 1; cmp_fld = 3'd6; cmp_a = 32'hFFFF_FFFF; cmp_b = 32'd1;
    cmp_unsigned = 1; xer_top = 4'b0000;
    step(); chk({28'd0, gf(cr_q, 6)}, 32'h4, "R8 unsigned gt");
    clear_reqs(); cmp_vld = 1; cmp_unsigned = 0;
    step(); chk({28'd0, gf(cr_q, 6)}, 32'h8, "R8 signed lt");

    // R6: self copy; R7: exception load with strobe; R4
    clear_reqs(); cpy_vld = 1; cpy_src = 3'd6; cpy_dst = 3'd6; step();
    clear_reqs(); xer_ld_vld = 1; xer_ld_fld = 3'd7; xer_top = 4'b1010; step();
    clear_reqs(); fp_rec_vld = 1; fp_status = 4'b0110; step();

    // R9: every opcode
    for (int op = 0; op < 8; op++) begin
      clear_reqs(); bit_vld = 1; bit_op = 3'(op);
      bit_a = 5'd0; bit_b = 5'd31; bit_dst = 5'(10 + op);
      step();
    end

    // R10: all requests at once, only the integer path acts
    clear_reqs();
    int_rec_vld = 1; fp_rec_vld = 1; mov_vld = 1; cpy_vld = 1;
    xer_ld_vld = 1; cmp_vld = 1; bit_vld = 1; int_result = 32'd5;
    step();

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int_rec_vld  = ($urandom % 5) == 0;
      fp_rec_vld   = ($urandom % 5) == 0;
      mov_vld      = ($urandom % 5) == 0;
      cpy_vld      = ($urandom % 4) == 0;
      xer_ld_vld   = ($urandom % 4) == 0;
      cmp_vld      = ($urandom % 3) == 0;
      bit_vld      = ($urandom % 2) == 0;
      int_result   = (($urandom % 4) == 0) ? 32'd0 : $urandom;
      fp_status    = 4'($urandom);
      mov_mask     = 8'($urandom);
      mov_data     = $urandom;
      cpy_src      = 3'($urandom);
      cpy_dst      = 3'($urandom);
      xer_ld_fld   = 3'($urandom);
      xer_top      = 4'($urandom);
      cmp_fld      = 3'($urandom);
      cmp_a        = $urandom;
      cmp_b        = (($urandom % 4) == 0) ? cmp_a : $urandom;
      cmp_unsigned = 1'($urandom);
      bit_op       = 3'($urandom);
      bit_a        = 5'($urandom);
      bit_b        = 5'($urandom);
      bit_dst      = 5'($urandom);
      test_idx     = 5'($urandom);
      step();
    end

    clear_reqs();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule